// File: doc/BRIEF.md
# Layer Pixel Expander with Colour Lookup

This block sits between a display layer's framebuffer fetch and the blending stage. Framebuffer bytes arrive one per beat. The block gathers them into pixels whose size depends on the selected pixel format. It then widens each pixel to a 32-bit alpha/red/green/blue word with 8 bits per channel. Three of the formats carry a luminance value instead of colour. For these, the luminance can index a 256-entry colour table that is loaded one entry at a time. When the table is switched off, the same formats produce plain grey.

Each completed pixel is also tested against the layer window. The window is given as offsets from the active area plus the accumulated back porch, so its bounds are in screen timing coordinates. Pixels outside the window take a default colour taken from an input. The same happens to every pixel when the layer is switched off. The result is one expanded pixel per completed input pixel, two clock edges after the pixel's final byte.

Top module: `pxl_expander`

## Requirements
- R1: While `rst_n` is low, `pix_valid` and `pix_argb` are 0. A pixel that is partly gathered when reset is asserted is discarded, and the next byte after reset starts a new pixel.
- R2: `fmt` selects the format with these codes: 0 ARGB8888, 1 RGB888, 2 RGB565, 3 ARGB1555, 4 ARGB4444, 5 L8, 6 AL44, 7 AL88. A pixel takes 4, 3, 2, 2, 2, 1, 1 or 2 bytes in that order, and the first byte is the least significant. If the final byte of a pixel is accepted at edge k, `pix_valid` is high for exactly the cycle after edge k+1, and the block makes no other outputs.
- R3: The output layout is A[31:24], R[23:16], G[15:8], B[7:0]. ARGB8888 passes through unchanged. RGB888 takes R, G and B from bits 23:16, 15:8 and 7:0 and sets alpha to 0xFF.
- R4: RGB565 takes R from bits 15:11, G from 10:5 and B from 4:0. Each channel is widened by repeating its top bits below it (5 bits: v*8 + v/4; 6 bits: v*4 + v/16), and alpha is 0xFF.
- R5: ARGB1555 takes alpha from bit 15 (0 gives 0x00, 1 gives 0xFF) and 5-bit R, G and B from bits 14:10, 9:5 and 4:0. ARGB4444 takes A, R, G and B from nibbles 15:12, 11:8, 7:4 and 3:0. Each nibble n becomes n*17.
- R6: With `clut_en` low, the luminance formats give R = G = B = L:
  - L8: L is bits 7:0 and alpha is 0xFF.
  - AL44: alpha is the upper nibble times 17, and L is the lower nibble times 17.
  - AL88: alpha is bits 15:8 and L is bits 7:0.
- R7: With `clut_en` high, the luminance formats take R, G and B from a table entry, and alpha stays as in R6. The entry index is bits 7:0 for L8 and AL88, and the lower nibble zero-extended for AL44.
- R8: A table write (`clut_we`) stores `clut_rgb` (R[23:16], G[15:8], B[7:0]) at `clut_addr`. The new entry is used by every pixel whose output is registered at a later edge. `clut_en` and the table contents do not affect formats 0 to 4.
- R9: A pixel is inside the window when both of these hold, using the `pos_x`/`pos_y` values at the edge that takes its final byte:
  - `acc_hbp + win_left + 1 <= pos_x <= acc_hbp + win_right`
  - `acc_vbp + win_top + 1 <= pos_y <= acc_vbp + win_bottom`

  An outside pixel is output as `dflt_argb` unchanged. A window whose right bound is not above its left bound, or whose bottom bound is not above its top bound, contains no pixel.
- R10: With `layer_en` low at the final byte, the pixel is output as `dflt_argb` whatever its format or position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fmt | input | 3 | Pixel format code |
| layer_en | input | 1 | Layer enable; when low, every pixel takes the default colour |
| clut_en | input | 1 | Route luminance formats through the colour table |
| clut_we | input | 1 | Colour table write strobe |
| clut_addr | input | 8 | Colour table write index |
| clut_rgb | input | 24 | Colour table write data, R/G/B |
| win_left | input | COORD_W (12) | Window left offset |
| win_right | input | COORD_W (12) | Window right offset |
| win_top | input | COORD_W (12) | Window top offset |
| win_bottom | input | COORD_W (12) | Window bottom offset |
| acc_hbp | input | COORD_W (12) | Accumulated horizontal back porch |
| acc_vbp | input | COORD_W (12) | Accumulated vertical back porch |
| pos_x | input | COORD_W (12) | Current horizontal screen timing position |
| pos_y | input | COORD_W (12) | Current vertical screen timing position |
| dflt_argb | input | 32 | Colour for pixels outside the window or on a disabled layer |
| byte_valid | input | 1 | A framebuffer byte is present |
| byte_data | input | 8 | Framebuffer byte |
| pix_valid | output | 1 | Expanded pixel is valid |
| pix_argb | output | 32 | Expanded pixel, A/R/G/B |

## Verification
The assertions assume the following about the inputs:
- `fmt` does not change while a pixel is partly gathered.
- `clut_en`, `dflt_argb` and the table contents are steady from a pixel's final byte until its output is registered.

The stimulus respects this in two ways. It changes format only at pixel boundaries. It inserts idle cycles before it touches any setting or writes the table. All other inputs (pixel values, coordinates, window offsets) are unconstrained, and the sweeps cover every byte value of the one-byte formats and every position of a small screen area.

// File: rtl/pxe_pkg.sv
package pxe_pkg;

  localparam int WORD_W = 32;
  localparam int LUM_W  = 8;
  localparam int RGB_W  = 24;

  typedef enum logic [2:0] {
    FMT_ARGB8888 = 3'd0,
    FMT_RGB888   = 3'd1,
    FMT_RGB565   = 3'd2,
    FMT_ARGB1555 = 3'd3,
    FMT_ARGB4444 = 3'd4,
    FMT_L8       = 3'd5,
    FMT_AL44     = 3'd6,
    FMT_AL88     = 3'd7
  } pix_fmt_e;

  // bytes that make up one pixel of the given format
  function automatic logic [2:0] bytes_per_pix(input pix_fmt_e f);
    case (f)
      FMT_ARGB8888:     return 3'd4;
      FMT_RGB888:       return 3'd3;
      FMT_L8, FMT_AL44: return 3'd1;
      default:          return 3'd2;
    endcase
  endfunction

  // channel widening by repeating the top bits underneath
  function automatic logic [7:0] widen4(input logic [3:0] v);
    return {v, v};
  endfunction

  function automatic logic [7:0] widen5(input logic [4:0] v);
    return {v, v[4:2]};
  endfunction

  function automatic logic [7:0] widen6(input logic [5:0] v);
    return {v, v[5:4]};
  endfunction

  function automatic logic is_lum(input pix_fmt_e f);
    return (f == FMT_L8) || (f == FMT_AL44) || (f == FMT_AL88);
  endfunction

  function automatic logic [7:0] lum_alpha(input pix_fmt_e f, input logic [WORD_W-1:0] raw);
    case (f)
      FMT_AL44: return widen4(raw[7:4]);
      FMT_AL88: return raw[15:8];
      default:  return 8'hFF;
    endcase
  endfunction

  function automatic logic [LUM_W-1:0] lum_index(input pix_fmt_e f, input logic [WORD_W-1:0] raw);
    if (f == FMT_AL44) return {4'h0, raw[3:0]};
    return raw[7:0];
  endfunction

  function automatic logic [7:0] lum_grey(input pix_fmt_e f, input logic [WORD_W-1:0] raw);
    if (f == FMT_AL44) return widen4(raw[3:0]);
    return raw[7:0];
  endfunction

  // expansion that needs no table
  function automatic logic [WORD_W-1:0] expand_direct(input pix_fmt_e f, input logic [WORD_W-1:0] raw);
    logic [7:0] g;
    g = lum_grey(f, raw);
    case (f)
      FMT_ARGB8888: return raw;
      FMT_RGB888:   return {8'hFF, raw[23:0]};
      FMT_RGB565:   return {8'hFF, widen5(raw[15:11]), widen6(raw[10:5]), widen5(raw[4:0])};
      FMT_ARGB1555: return {{8{raw[15]}}, widen5(raw[14:10]), widen5(raw[9:5]), widen5(raw[4:0])};
      FMT_ARGB4444: return {widen4(raw[15:12]), widen4(raw[11:8]), widen4(raw[7:4]), widen4(raw[3:0])};
      default:      return {lum_alpha(f, raw), g, g, g};
    endcase
  endfunction

endpackage

// File: rtl/pxe_gather.sv
module pxe_gather
  import pxe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  pix_fmt_e          fmt,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  output logic              word_done,
  output logic [WORD_W-1:0] word_raw
);

  localparam int LANES = WORD_W / 8;
  localparam int CNT_W = $clog2(LANES);

  logic [CNT_W-1:0]         cnt_q;
  logic [LANES-2:0][7:0]    acc_q;
  logic [LANES-1:0][7:0]    acc_ext;
  logic [2:0]               need;
  logic                     at_last;

  assign need      = bytes_per_pix(fmt);
  assign at_last   = ({1'b0, cnt_q} == need - 3'd1);
  assign word_done = byte_valid && at_last;
  assign acc_ext   = {8'h00, acc_q};

  // lanes below the counter come from storage, the current lane from the input
  always_comb begin
    word_raw = '0;
    for (int b = 0; b < LANES; b++) begin
      if (b == int'(cnt_q))     word_raw[b*8 +: 8] = byte_data;
      else if (b < int'(cnt_q)) word_raw[b*8 +: 8] = acc_ext[b];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else if (byte_valid) begin
      if (at_last) begin
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        for (int b = 0; b < LANES - 1; b++)
          if (b == int'(cnt_q)) acc_q[b] <= byte_data;
      end
    end
  end

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, cnt_q} < need);

  p_fmt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> $stable(fmt));

  p_done_restarts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> (cnt_q == '0));

endmodule

// File: rtl/pxe_clut.sv
module pxe_clut #(
  parameter  int DEPTH  = 256,
  parameter  int DATA_W = 24,
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];

  p_write_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mem_q[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/pxe_window.sv
module pxe_window #(
  parameter int COORD_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [COORD_W-1:0] pos_x,
  input  logic [COORD_W-1:0] pos_y,
  input  logic [COORD_W-1:0] lo_x,
  input  logic [COORD_W-1:0] hi_x,
  input  logic [COORD_W-1:0] lo_y,
  input  logic [COORD_W-1:0] hi_y,
  input  logic [COORD_W-1:0] bp_x,
  input  logic [COORD_W-1:0] bp_y,
  output logic               win_hit
);

  localparam int SUM_W = COORD_W + 2;

  logic [1:0][COORD_W-1:0] pos_a, lo_a, hi_a, bp_a;
  logic [1:0]              axis_hit;

  assign pos_a = {pos_y, pos_x};
  assign lo_a  = {lo_y,  lo_x};
  assign hi_a  = {hi_y,  hi_x};
  assign bp_a  = {bp_y,  bp_x};

  // one identical range test per axis, bounds moved into timing coordinates
  for (genvar a = 0; a < 2; a++) begin : g_axis
    logic [SUM_W-1:0] first_pos, last_pos, cur_pos;
    assign first_pos   = SUM_W'(bp_a[a]) + SUM_W'(lo_a[a]) + SUM_W'(1);
    assign last_pos    = SUM_W'(bp_a[a]) + SUM_W'(hi_a[a]);
    assign cur_pos     = SUM_W'(pos_a[a]);
    assign axis_hit[a] = (cur_pos >= first_pos) && (cur_pos <= last_pos);
  end

  assign win_hit = &axis_hit;

  p_empty_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((hi_x <= lo_x) || (hi_y <= lo_y)) |-> !win_hit);

  p_hit_past_porch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    win_hit |-> ((pos_x > bp_x) && (pos_y > bp_y)));

endmodule

// File: rtl/pxl_expander.sv
module pxl_expander
  import pxe_pkg::*;
#(
  parameter int COORD_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         fmt,
  input  logic               layer_en,
  input  logic               clut_en,
  input  logic               clut_we,
  input  logic [7:0]         clut_addr,
  input  logic [23:0]        clut_rgb,
  input  logic [COORD_W-1:0] win_left,
  input  logic [COORD_W-1:0] win_right,
  input  logic [COORD_W-1:0] win_top,
  input  logic [COORD_W-1:0] win_bottom,
  input  logic [COORD_W-1:0] acc_hbp,
  input  logic [COORD_W-1:0] acc_vbp,
  input  logic [COORD_W-1:0] pos_x,
  input  logic [COORD_W-1:0] pos_y,
  input  logic [31:0]        dflt_argb,
  input  logic               byte_valid,
  input  logic [7:0]         byte_data,
  output logic               pix_valid,
  output logic [31:0]        pix_argb
);

  localparam int LUT_DEPTH = 1 << LUM_W;

  pix_fmt_e          fmt_e;
  logic              word_done;
  logic [WORD_W-1:0] word_raw;
  logic              win_hit;

  // stage A: gathered pixel
  logic              a_valid;
  logic [WORD_W-1:0] a_raw;
  pix_fmt_e          a_fmt;
  logic              a_show;

  // stage B decision wires
  logic              lum_path;
  logic              clut_path;
  logic [LUM_W-1:0]  clut_idx;
  logic [RGB_W-1:0]  clut_rd;
  logic [WORD_W-1:0] next_argb;

  assign fmt_e = pix_fmt_e'(fmt);

  pxe_gather u_gather (
    .clk        (clk),
    .rst_n      (rst_n),
    .fmt        (fmt_e),
    .byte_valid (byte_valid),
    .byte_data  (byte_data),
    .word_done  (word_done),
    .word_raw   (word_raw)
  );

  pxe_window #(.COORD_W(COORD_W)) u_window (
    .clk     (clk),
    .rst_n   (rst_n),
    .pos_x   (pos_x),
    .pos_y   (pos_y),
    .lo_x    (win_left),
    .hi_x    (win_right),
    .lo_y    (win_top),
    .hi_y    (win_bottom),
    .bp_x    (acc_hbp),
    .bp_y    (acc_vbp),
    .win_hit (win_hit)
  );

  pxe_clut #(.DEPTH(LUT_DEPTH), .DATA_W(RGB_W)) u_clut (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (clut_we),
    .waddr (clut_addr),
    .wdata (clut_rgb),
    .raddr (clut_idx),
    .rdata (clut_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_valid <= 1'b0;
      a_raw   <= '0;
      a_fmt   <= FMT_ARGB8888;
      a_show  <= 1'b0;
    end else begin
      a_valid <= word_done;
      if (word_done) begin
        a_raw  <= word_raw;
        a_fmt  <= fmt_e;
        a_show <= layer_en && win_hit;
      end
    end
  end

  assign lum_path  = is_lum(a_fmt);
  assign clut_path = lum_path && clut_en;
  assign clut_idx  = lum_index(a_fmt, a_raw);

  always_comb begin
    if (!a_show)        next_argb = dflt_argb;
    else if (clut_path) next_argb = {lum_alpha(a_fmt, a_raw), clut_rd};
    else                next_argb = expand_direct(a_fmt, a_raw);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_valid <= 1'b0;
      pix_argb  <= '0;
    end else begin
      pix_valid <= a_valid;
      if (a_valid) pix_argb <= next_argb;
    end
  end

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    a_valid |=> pix_valid);

  p_no_stray_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !a_valid |=> !pix_valid);

  p_hidden_default_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (a_valid && !a_show) |=> (pix_argb == $past(dflt_argb)));

  p_layer_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && !layer_en) |=> (a_valid && !a_show));

  p_opaque_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (a_valid && a_show && ((a_fmt == FMT_RGB888) || (a_fmt == FMT_RGB565) || (a_fmt == FMT_L8)))
    |=> (pix_argb[31:24] == 8'hFF));

  p_alpha_1bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (a_valid && a_show && (a_fmt == FMT_ARGB1555))
    |=> ((pix_argb[31:24] == 8'h00) || (pix_argb[31:24] == 8'hFF)));

endmodule

// File: tb/sim_pxl_expander.sv
module sim_pxl_expander;

  localparam int CW = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [2:0]    fmt;
  logic          layer_en, clut_en, clut_we;
  logic [7:0]    clut_addr;
  logic [23:0]   clut_rgb;
  logic [CW-1:0] win_left, win_right, win_top, win_bottom;
  logic [CW-1:0] acc_hbp, acc_vbp, pos_x, pos_y;
  logic [31:0]   dflt_argb;
  logic          byte_valid;
  logic [7:0]    byte_data;
  logic          pix_valid;
  logic [31:0]   pix_argb;

  int          checks = 0;
  int          fails  = 0;
  bit          done   = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [23:0] lut_m [256];

  always #10 clk = ~clk;

  pxl_expander #(.COORD_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .fmt(fmt), .layer_en(layer_en), .clut_en(clut_en),
    .clut_we(clut_we), .clut_addr(clut_addr), .clut_rgb(clut_rgb),
    .win_left(win_left), .win_right(win_right), .win_top(win_top), .win_bottom(win_bottom),
    .acc_hbp(acc_hbp), .acc_vbp(acc_vbp), .pos_x(pos_x), .pos_y(pos_y),
    .dflt_argb(dflt_argb), .byte_valid(byte_valid), .byte_data(byte_data),
    .pix_valid(pix_valid), .pix_argb(pix_argb)
  );

  function automatic logic [7:0] x4(logic [3:0] v); return 8'(int'(v) * 17); endfunction
  function automatic logic [7:0] x5(logic [4:0] v); return 8'(int'(v) * 8 + int'(v) / 4); endfunction
  function automatic logic [7:0] x6(logic [5:0] v); return 8'(int'(v) * 4 + int'(v) / 16); endfunction

  function automatic int nbytes(int f);
    case (f)
      0: return 4;
      1: return 3;
      5, 6: return 1;
      default: return 2;
    endcase
  endfunction

  function automatic logic [31:0] mix(int i, int f);
    logic [31:0] m;
    if (i == 1) return 32'hFFFF_FFFF;
    m = 32'(i) * 32'h9E37_79B1;
    return m ^ (32'(f) << 27);
  endfunction

  function automatic logic [31:0] model(int f, logic [31:0] w, int x, int y);
    int hs, he, vs, ve, idx;
    bit lum;
    logic [7:0] a, r, g, b, l;
    hs = int'(acc_hbp) + int'(win_left) + 1;
    he = int'(acc_hbp) + int'(win_right);
    vs = int'(acc_vbp) + int'(win_top) + 1;
    ve = int'(acc_vbp) + int'(win_bottom);
    if (!layer_en || x < hs || x > he || y < vs || y > ve) return dflt_argb;
    lum = 0; idx = 0; a = 8'hFF; r = 0; g = 0; b = 0; l = 0;
    case (f)
      0: begin a = w[31:24]; r = w[23:16]; g = w[15:8]; b = w[7:0]; end
      1: begin r = w[23:16]; g = w[15:8]; b = w[7:0]; end
      2: begin r = x5(w[15:11]); g = x6(w[10:5]); b = x5(w[4:0]); end
      3: begin a = w[15] ? 8'hFF : 8'h00; r = x5(w[14:10]); g = x5(w[9:5]); b = x5(w[4:0]); end
      4: begin a = x4(w[15:12]); r = x4(w[11:8]); g = x4(w[7:4]); b = x4(w[3:0]); end
      5: begin lum = 1; l = w[7:0]; idx = int'(w[7:0]); end
      6: begin lum = 1; a = x4(w[7:4]); l = x4(w[3:0]); idx = int'(w[3:0]); end
      default: begin lum = 1; a = w[15:8]; l = w[7:0]; idx = int'(w[7:0]); end
    endcase
    if (lum) begin
      if (clut_en) {r, g, b} = lut_m[idx];
      else begin r = l; g = l; b = l; end
    end
    return {a, r, g, b};
  endfunction

  function automatic string fmt_tag(int f);
    if (f <= 1) return "R3";
    if (f == 2) return "R4";
    if (f <= 4) return "R5";
    return clut_en ? "R7" : "R6";
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  // output monitor: every valid pixel must match the next expected one
  always @(negedge clk) begin
    if (rst_n && pix_valid) begin
      if (exp_q.size() == 0) begin
        checks++;
        fails++;
        $display("FAIL R2 actual=%h expected=no output", pix_argb);
      end else begin
        check(tag_q.pop_front(), pix_argb, exp_q.pop_front());
      end
    end
  end

  task automatic push(int f, logic [31:0] w, int x, int y, string tag);
    exp_q.push_back(model(f, w, x, y));
    tag_q.push_back(tag);
    for (int b = 0; b < nbytes(f); b++) begin
      @(negedge clk);
      fmt        = 3'(f);
      byte_valid = 1'b1;
      byte_data  = w[8*b +: 8];
      pos_x      = CW'(x);
      pos_y      = CW'(y);
    end
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      byte_valid = 1'b0;
    end
  endtask

  task automatic lut_write(int i, logic [23:0] v);
    @(negedge clk);
    clut_we   = 1'b1;
    clut_addr = 8'(i);
    clut_rgb  = v;
    lut_m[i]  = v;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; fmt = 3'd0; layer_en = 1'b1; clut_en = 1'b0; clut_we = 1'b0;
    clut_addr = 8'h00; clut_rgb = 24'h0; dflt_argb = 32'h0;
    acc_hbp = CW'(5); acc_vbp = CW'(3);
    win_left = CW'(4); win_right = CW'(20); win_top = CW'(2); win_bottom = CW'(9);
    pos_x = '0; pos_y = '0; byte_valid = 1'b0; byte_data = 8'h00;

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", {31'b0, pix_valid}, 32'd0);
    check("R1", pix_argb, 32'd0);
    rst_n = 1'b1;

    // fill the colour table
    for (int i = 0; i < 256; i++)
      lut_write(i, {8'(i * 7 + 3), 8'(255 - i), 8'(i) ^ 8'h5A});
    @(negedge clk);
    clut_we = 1'b0;

    // R2: output appears exactly two edges after the final byte
    idle(3);
    push(5, 32'h42, 15, 8, "R2");
    @(negedge clk);
    byte_valid = 1'b0;
    check("R2", {31'b0, pix_valid}, 32'd0);
    @(negedge clk);
    check("R2", {31'b0, pix_valid}, 32'd1);
    idle(3);

    // format sweeps with the table off (R3..R6), back to back
    for (int f = 0; f < 8; f++) begin
      int n;
      n = (f == 5 || f == 6) ? 256 : 300;
      for (int i = 0; i < n; i++)
        push(f, (f == 5 || f == 6) ? 32'(i) : mix(i, f), 10 + (i % 16), 6 + (i % 7), fmt_tag(f));
    end
    idle(4);

    // R7: luminance through the table; R8: table ignored by colour formats
    clut_en = 1'b1;
    for (int i = 0; i < 256; i++) push(5, 32'(i), 15, 8, "R7");
    for (int i = 0; i < 256; i++) push(6, 32'(i), 15, 8, "R7");
    for (int i = 0; i < 300; i++) push(7, mix(i, 7), 15, 8, "R7");
    for (int i = 0; i < 100; i++) push(2, mix(i, 2), 15, 8, "R8");
    for (int i = 0; i < 100; i++) push(0, mix(i, 0), 15, 8, "R8");
    idle(4);

    // R8: rewritten entries are used by later pixels
    lut_write(8'h3C, 24'hA1B2C3);
    lut_write(8'h05, 24'h0F1E2D);
    @(negedge clk);
    clut_we = 1'b0;
    push(5, 32'h3C, 15, 8, "R8");
    push(6, 32'hA5, 15, 8, "R8");
    push(7, 32'h7F3C, 15, 8, "R8");
    idle(4);

    // R9: window sweep over a small screen area
    clut_en   = 1'b0;
    dflt_argb = 32'hC0FF_EE01;
    for (int y = 0; y < 16; y++)
      for (int x = 0; x < 32; x++)
        push(5, 32'(x * 8 + y), x, y, "R9");
    idle(4);
    win_right = win_left;
    for (int i = 0; i < 20; i++) push(2, mix(i, 9), 5 + i, 8, "R9");
    idle(4);
    win_right = CW'(20);
    win_bottom = win_top;
    for (int i = 0; i < 10; i++) push(5, 32'(i), 15, i, "R9");
    idle(4);
    win_bottom = CW'(9);

    // R10: disabled layer always shows the default colour
    layer_en  = 1'b0;
    dflt_argb = 32'h8040_2010;
    for (int i = 0; i < 24; i++) push(i % 8, mix(i, 3), 15, 8, "R10");
    idle(4);
    layer_en = 1'b1;

    // R1: a partly gathered pixel is dropped by reset
    @(negedge clk);
    fmt = 3'd0; byte_valid = 1'b1; byte_data = 8'hAA;
    @(negedge clk);
    byte_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", {31'b0, pix_valid}, 32'd0);
    rst_n = 1'b1;
    push(0, 32'h1122_3344, 15, 8, "R1");
    idle(6);

    // R2: every expected pixel was produced
    check("R2", 32'(exp_q.size()), 32'd0);

    done = 1;
    summary();
    $finish;
  end

endmodule